// File: doc/BRIEF.md
# Serial Configuration Stream Loader with Chain Pass-Through

This block takes a serial configuration stream, one bit for each accepted transfer, and splits it into a header and a fixed number of frames. The header is a leader of ones, a four-bit start code and a 24-bit length value. Each frame carries start bits that are skipped, a data payload and a check field. A frame whose check field matches a fixed pattern is handed out on a parallel valid/ready port. A mismatch stops loading for good and raises a sticky error flag, which the surrounding logic can use to pull its init line low.

A single `dout` pin feeds the next device in a chain. In normal chain mode the header is echoed downstream, the pin is held high while local frames load so that frame start bits never reach the next device, and echoing resumes once every local frame is in. In express mode the length value is ignored and `dout` acts as an enable: it stays low until this device is done, then goes high. One early data bit of the first frame selects the fast configuration clock and is reported on `fast_sel`.

Back-pressure: a loaded frame stays on `frm_data`/`frm_idx` with `frm_valid` high until `frm_ready` is seen. While a frame is held and `frm_ready` is low, `in_ready` is low and the serial source must hold its bit. A bit counts only on a clock edge where `in_valid` and `in_ready` are both high.

Top module: `cfg_stream_loader`

## Requirements
- R1: After reset, any number of leading ones (zero included) is skipped. The bits 0,0,1,0 in that order mark the stream start. The next LEN_W bits, MSB first, are the length value.
- R2: Each frame is START_W ignored bits, then FRAME_W data bits, then ERR_W check bits, each field MSB first. A frame whose check field equals ERR_PAT appears on `frm_data` with its zero-based number on `frm_idx` and `frm_valid` high, starting on the edge after its last check bit.
- R3: While `frm_valid` is high and `frm_ready` is low, the frame outputs stay unchanged and `in_ready` is low. An edge without an accepted bit changes none of `dout`, `done`, `err` and `fast_sel`.
- R4: In normal mode `dout` is updated on the edge that accepts each bit. It equals that bit during the leader, start code and length, equals 1 for every frame bit, and equals the bit again once all NUM_FRAMES frames have loaded.
- R5: A check-field mismatch sets `err` on the edge that accepts the last check bit. `err` then stays set, that frame and all later frames are not output, `done` never rises, and in normal mode `dout` stays 1.
- R6: In normal mode `done` rises on the edge where the count of accepted bits since reset reaches the length value plus 4, and stays high.
- R7: In express mode the length value has no effect. `done` rises on the fourth accepted bit after the last check bit of the last frame, and `dout` is 0 before `done` and 1 after.
- R8: `fast_sel` is 0 after reset. It takes the value of data bit RATE_POS of frame 0 (counting from 0 at the first data bit) on the edge that accepts that bit. Later frames do not change it.
- R9: In reset, `done`, `err`, `fast_sel` and `frm_valid` are 0, `in_ready` is 1, and `dout` is 1 in normal mode and 0 in express mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low synchronous reset |
| express | input | 1 | 1 selects express chain-enable mode, 0 normal chain mode |
| in_valid | input | 1 | Serial bit present |
| in_ready | output | 1 | Serial bit accepted when high together with in_valid |
| in_bit | input | 1 | Serial configuration bit |
| frm_valid | output | 1 | Loaded frame available |
| frm_ready | input | 1 | Consumer takes the frame |
| frm_data | output | FRAME_W | Frame payload, first received bit in the MSB |
| frm_idx | output | IDX_W | Zero-based frame number |
| dout | output | 1 | Downstream chain output |
| done | output | 1 | Configuration complete, sticky |
| err | output | 1 | Frame check error, sticky |
| fast_sel | output | 1 | Fast configuration clock select |

## Verification
The bench sweeps leader lengths from zero to five ones across both chain modes, with different frame payload seeds. Each accepted bit is checked against a position-based expectation for `dout`, `done`, `err` and `fast_sel`. A length value equal to the frame-stream end, and one six bits beyond it, tells a length-driven `done` apart from one driven by frame completion, while a small length value in express mode shows that it is ignored. Runs with `frm_ready` stalls and idle input cycles separate accepted bits from offered ones. A corrupted check field in frame 0 or frame 1 shows that the halt point, the missing frames and the held `dout` level all line up.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  typedef enum logic [2:0] {
    PH_HDR   = 3'd0,
    PH_LEN   = 3'd1,
    PH_START = 3'd2,
    PH_DATA  = 3'd3,
    PH_CHK   = 3'd4,
    PH_PASS  = 3'd5,
    PH_HALT  = 3'd6
  } phase_t;

  localparam logic [3:0] SYNC_CODE = 4'b0010;
  localparam int TAIL_CLOCKS = 4;
endpackage

// File: rtl/cfgld_seq.sv
module cfgld_seq
  import cfgld_pkg::*;
#(
  parameter int LEN_W      = 24,
  parameter int START_W    = 2,
  parameter int FRAME_W    = 16,
  parameter int ERR_W      = 4,
  parameter int NUM_FRAMES = 4,
  parameter int RATE_POS   = 0,
  parameter int IDX_W      = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             bit_in,
  input  logic             express,
  input  logic             chk_ok,
  output phase_t           phase,
  output logic             last_chk,
  output logic [IDX_W-1:0] frame_idx,
  output logic             done,
  output logic             err,
  output logic             fast_sel
);
  localparam int MAX_A  = (LEN_W > START_W) ? LEN_W : START_W;
  localparam int MAX_B  = (FRAME_W > ERR_W) ? FRAME_W : ERR_W;
  localparam int MAXF   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int FC_W   = $clog2(MAXF + 1);
  localparam int CNT_W  = LEN_W + 2;

  logic [FC_W-1:0]  fcnt;
  logic [FC_W-1:0]  flen;
  logic             field_end;
  logic [2:0]       sync_sh;
  logic [LEN_W-2:0] len_sh;
  logic [CNT_W-1:0] clk_cnt;
  logic [CNT_W-1:0] thr;
  logic             thr_v;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    case (phase)
      PH_LEN:   flen = FC_W'(LEN_W);
      PH_START: flen = FC_W'(START_W);
      PH_DATA:  flen = FC_W'(FRAME_W);
      PH_CHK:   flen = FC_W'(ERR_W);
      default:  flen = FC_W'(1);
    endcase
  end

  assign field_end = (fcnt == flen - FC_W'(1));
  assign last_chk  = take && (phase == PH_CHK) && field_end;
  assign cnt_nxt   = clk_cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_HDR;
      fcnt      <= '0;
      sync_sh   <= 3'b111;
      len_sh    <= '0;
      frame_idx <= '0;
      clk_cnt   <= '0;
      thr       <= '0;
      thr_v     <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      fast_sel  <= 1'b0;
    end else if (take && (phase != PH_HALT)) begin
      clk_cnt <= cnt_nxt;
      if (thr_v && (cnt_nxt == thr)) done <= 1'b1;
      fcnt <= field_end ? '0 : fcnt + FC_W'(1);
      case (phase)
        PH_HDR: begin
          fcnt    <= '0;
          sync_sh <= {sync_sh[1:0], bit_in};
          if ({sync_sh, bit_in} == SYNC_CODE) phase <= PH_LEN;
        end
        PH_LEN: begin
          len_sh <= {len_sh[LEN_W-3:0], bit_in};
          if (field_end) begin
            phase <= PH_START;
            if (!express) begin
              thr   <= CNT_W'({len_sh, bit_in}) + CNT_W'(TAIL_CLOCKS);
              thr_v <= 1'b1;
            end
          end
        end
        PH_START: begin
          if (field_end) phase <= PH_DATA;
        end
        PH_DATA: begin
          if ((frame_idx == '0) && (fcnt == FC_W'(RATE_POS))) fast_sel <= bit_in;
          if (field_end) phase <= PH_CHK;
        end
        PH_CHK: begin
          if (field_end) begin
            if (!chk_ok) begin
              phase <= PH_HALT;
              err   <= 1'b1;
            end else if (frame_idx == IDX_W'(NUM_FRAMES - 1)) begin
              phase <= PH_PASS;
              if (express) begin
                thr   <= cnt_nxt + CNT_W'(TAIL_CLOCKS);
                thr_v <= 1'b1;
              end
            end else begin
              phase     <= PH_START;
              frame_idx <= frame_idx + IDX_W'(1);
            end
          end
        end
        default: fcnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/cfgld_frame.sv
module cfgld_frame
  import cfgld_pkg::*;
#(
  parameter int               FRAME_W = 16,
  parameter int               ERR_W   = 4,
  parameter logic [ERR_W-1:0] ERR_PAT = ERR_W'(10),
  parameter int               IDX_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic               bit_in,
  input  phase_t             phase,
  input  logic               last_chk,
  input  logic [IDX_W-1:0]   frame_idx,
  output logic               chk_ok,
  output logic               frm_valid,
  input  logic               frm_ready,
  output logic [FRAME_W-1:0] frm_data,
  output logic [IDX_W-1:0]   frm_idx
);
  logic [FRAME_W-1:0] data_sh;
  logic [ERR_W-2:0]   chk_sh;

  assign chk_ok = ({chk_sh, bit_in} == ERR_PAT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_sh <= '0;
      chk_sh  <= '0;
    end else if (take) begin
      if (phase == PH_DATA) data_sh <= {data_sh[FRAME_W-2:0], bit_in};
      if (phase == PH_CHK)  chk_sh  <= {chk_sh[ERR_W-3:0], bit_in};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_valid <= 1'b0;
      frm_data  <= '0;
      frm_idx   <= '0;
    end else if (last_chk && chk_ok) begin
      frm_valid <= 1'b1;
      frm_data  <= data_sh;
      frm_idx   <= frame_idx;
    end else if (frm_ready) begin
      frm_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cfgld_dout.sv
module cfgld_dout
  import cfgld_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   take,
  input  logic   bit_in,
  input  phase_t phase,
  input  logic   express,
  input  logic   done,
  output logic   dout
);
  logic chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= 1'b1;
    end else if (take) begin
      case (phase)
        PH_HDR, PH_LEN, PH_PASS: chain_q <= bit_in;
        default:                 chain_q <= 1'b1;
      endcase
    end
  end

  assign dout = express ? done : chain_q;
endmodule

// File: rtl/cfg_stream_loader.sv
module cfg_stream_loader
  import cfgld_pkg::*;
#(
  parameter int               LEN_W      = 24,
  parameter int               START_W    = 2,
  parameter int               FRAME_W    = 16,
  parameter int               ERR_W      = 4,
  parameter int               NUM_FRAMES = 4,
  parameter int               RATE_POS   = 0,
  parameter logic [ERR_W-1:0] ERR_PAT    = ERR_W'(10),
  localparam int              IDX_W      = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               express,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_bit,
  output logic               frm_valid,
  input  logic               frm_ready,
  output logic [FRAME_W-1:0] frm_data,
  output logic [IDX_W-1:0]   frm_idx,
  output logic               dout,
  output logic               done,
  output logic               err,
  output logic               fast_sel
);
  phase_t           phase;
  logic             take;
  logic             last_chk;
  logic             chk_ok;
  logic [IDX_W-1:0] frame_idx;

  assign in_ready = !(frm_valid && !frm_ready);
  assign take     = in_valid && in_ready;

  cfgld_seq #(
    .LEN_W(LEN_W), .START_W(START_W), .FRAME_W(FRAME_W), .ERR_W(ERR_W),
    .NUM_FRAMES(NUM_FRAMES), .RATE_POS(RATE_POS), .IDX_W(IDX_W)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit), .express(express),
    .chk_ok(chk_ok), .phase(phase), .last_chk(last_chk), .frame_idx(frame_idx),
    .done(done), .err(err), .fast_sel(fast_sel)
  );

  cfgld_frame #(
    .FRAME_W(FRAME_W), .ERR_W(ERR_W), .ERR_PAT(ERR_PAT), .IDX_W(IDX_W)
  ) u_frame (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit), .phase(phase),
    .last_chk(last_chk), .frame_idx(frame_idx), .chk_ok(chk_ok),
    .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data), .frm_idx(frm_idx)
  );

  cfgld_dout u_dout (
    .clk(clk), .rst_n(rst_n), .take(take), .bit_in(in_bit), .phase(phase),
    .express(express), .done(done), .dout(dout)
  );
endmodule

// File: rtl/cfg_stream_loader_chk.sv
module cfg_stream_loader_chk #(
  parameter int FRAME_W = 16,
  parameter int IDX_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               frm_valid,
  input logic               frm_ready,
  input logic [FRAME_W-1:0] frm_data,
  input logic [IDX_W-1:0]   frm_idx,
  input logic               dout,
  input logic               done,
  input logic               err,
  input logic               fast_sel
);
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) err |=> err); // R5
  AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n) !(done && err)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) done |=> done); // R6
  AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && !frm_ready) |=> (frm_valid && $stable(frm_data) && $stable(frm_idx))); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_ready) |=> ($stable(dout) && $stable(done) && $stable(err) && $stable(fast_sel))); // R3
  AST_FAST_KEEP: assert property (@(posedge clk) disable iff (!rst_n) fast_sel |=> fast_sel); // R8
endmodule

bind cfg_stream_loader cfg_stream_loader_chk #(
  .FRAME_W(FRAME_W), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data), .frm_idx(frm_idx),
  .dout(dout), .done(done), .err(err), .fast_sel(fast_sel)
);

// File: tb/tb_cfg_stream_loader.sv
module tb_cfg_stream_loader;
  localparam int FW = 8;
  localparam int NF = 3;
  localparam int SW = 2;
  localparam int EW = 4;
  localparam int LW = 24;
  localparam int RP = 1;
  localparam int IW = 2;
  localparam int FL = SW + FW + EW;
  localparam logic [EW-1:0] EPAT = 4'b1010;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic express = 1'b0;
  logic in_valid = 1'b0;
  logic in_bit = 1'b0;
  logic frm_ready = 1'b1;
  logic in_ready, frm_valid, dout, done, err, fast_sel;
  logic [FW-1:0] frm_data;
  logic [IW-1:0] frm_idx;

  cfg_stream_loader #(
    .LEN_W(LW), .START_W(SW), .FRAME_W(FW), .ERR_W(EW),
    .NUM_FRAMES(NF), .RATE_POS(RP), .ERR_PAT(EPAT)
  ) dut (
    .clk(clk), .rst_n(rst_n), .express(express), .in_valid(in_valid), .in_ready(in_ready),
    .in_bit(in_bit), .frm_valid(frm_valid), .frm_ready(frm_ready), .frm_data(frm_data),
    .frm_idx(frm_idx), .dout(dout), .done(done), .err(err), .fast_sel(fast_sel)
  );

  always #4 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  logic s [0:255];
  int hdr_end, frm_end, n_bits, done_at, bad_end, n_frm, seed_g;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [FW-1:0] fdata(input int f, input int seed);
    return FW'((f * 53 + seed * 29 + 7) % 256);
  endfunction

  task automatic grab();
    if (frm_valid && frm_ready) begin
      chk("R2 frame data", 32'(frm_data), 32'(fdata(n_frm, seed_g)));
      chk("R2 frame index", 32'(frm_idx), 32'(n_frm));
      n_frm++;
    end
  endtask

  task automatic run(input int lead, input logic xm, input int len_extra, input int bad,
                     input logic stalls, input logic gaps, input int seed);
    int k;
    int lenv;
    logic e_dout, e_done, e_err, e_fast;
    int i;
    int cyc;
    logic acc;
    string dtag;
    seed_g  = seed;
    hdr_end = lead + 4 + LW;
    frm_end = hdr_end + NF * FL;
    n_bits  = frm_end + 12;
    lenv    = xm ? 3 : frm_end + len_extra;
    done_at = xm ? frm_end + 4 : lenv + 4;
    bad_end = (bad >= 0) ? hdr_end + bad * FL + FL - 1 : 100000;
    k = 0;
    for (int j = 0; j < lead; j++) begin s[k] = 1'b1; k++; end
    s[k] = 1'b0; s[k+1] = 1'b0; s[k+2] = 1'b1; s[k+3] = 1'b0; k += 4;
    for (int j = LW - 1; j >= 0; j--) begin s[k] = lenv[j]; k++; end
    for (int f = 0; f < NF; f++) begin
      logic [FW-1:0] d;
      d = fdata(f, seed);
      for (int j = 0; j < SW; j++) begin s[k] = 1'b0; k++; end
      for (int j = FW - 1; j >= 0; j--) begin s[k] = d[j]; k++; end
      for (int j = EW - 1; j >= 0; j--) begin
        s[k] = (f == bad) ? ~EPAT[j] : EPAT[j];
        k++;
      end
    end
    for (int j = 0; j < 12; j++) begin s[k] = ((k * 7) % 5) > 2; k++; end

    // Reset state (R9)
    @(negedge clk);
    rst_n = 1'b0; express = xm; in_valid = 1'b0; frm_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk("R9 dout in reset", 32'(dout), 32'(!xm));
    chk("R9 done in reset", 32'(done), 0);
    chk("R9 err in reset", 32'(err), 0);
    chk("R9 fast_sel in reset", 32'(fast_sel), 0);
    chk("R9 frm_valid in reset", 32'(frm_valid), 0);
    chk("R9 in_ready in reset", 32'(in_ready), 1);
    @(negedge clk);
    rst_n = 1'b1;

    n_frm = 0;
    e_dout = !xm; e_done = 1'b0; e_err = 1'b0; e_fast = 1'b0;
    dtag = xm ? "R7 dout" : ((bad >= 0) ? "R5 dout" : "R4 dout");
    i = 0;
    cyc = 0;
    while (i < n_bits) begin
      @(negedge clk);
      frm_ready = stalls ? ((cyc % 3) == 0) : 1'b1;
      in_valid  = gaps ? ((cyc % 4) != 2) : 1'b1;
      in_bit    = in_valid ? s[i] : ~s[i];
      #1;
      grab();
      if (frm_valid && !frm_ready) chk("R3 in_ready low while frame held", 32'(in_ready), 0);
      acc = in_valid && in_ready;
      @(posedge clk);
      #1;
      if (acc) begin
        e_err  = (i >= bad_end);
        e_done = (bad < 0) && (i + 1 >= done_at);
        e_fast = (i >= hdr_end + SW + RP) ? s[hdr_end + SW + RP] : 1'b0;
        if (xm) e_dout = e_done;
        else if (e_err) e_dout = 1'b1;
        else e_dout = (i < hdr_end || i >= frm_end) ? s[i] : 1'b1;
        i++;
        chk(dtag, 32'(dout), 32'(e_dout));
        chk(xm ? "R7 done" : "R6 done", 32'(done), 32'(e_done));
        chk("R5 err", 32'(err), 32'(e_err));
        chk("R8 fast_sel", 32'(fast_sel), 32'(e_fast));
      end else begin
        chk("R3 idle dout", 32'(dout), 32'(e_dout));
        chk("R3 idle done", 32'(done), 32'(e_done));
        chk("R3 idle err", 32'(err), 32'(e_err));
      end
      cyc++;
    end
    repeat (6) begin
      @(negedge clk);
      in_valid = 1'b0; frm_ready = 1'b1;
      #1;
      grab();
      @(posedge clk);
    end
    chk("R1 R2 frame count", 32'(n_frm), 32'((bad >= 0) ? bad : NF));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    run(0, 1'b0, 0, -1, 1'b0, 1'b0, 1);
    run(3, 1'b0, 6, -1, 1'b1, 1'b1, 2);
    run(5, 1'b1, 0, -1, 1'b1, 1'b0, 3);
    run(2, 1'b0, 0, 1, 1'b0, 1'b1, 4);
    run(1, 1'b1, 0, 0, 1'b0, 1'b0, 5);
    run(4, 1'b0, 0, -1, 1'b0, 1'b0, 6);
    run(2, 1'b1, 0, -1, 1'b0, 1'b1, 7);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule